// File: doc/BRIEF.md
# Double-Buffered SPI Port

This block is a byte-to-halfword SPI port that runs either as bus master or as a slave to an external master. Both directions are double buffered. Software writes a word into a transmit holding register that sits in front of the transmit shifter. Completed received words move from the receive shifter into a receive data register. The receive side and the transmit side each keep their own status bits, so software can queue the next word or collect the last one without waiting for the current word to finish shifting.

Software talks to the block over a small register bus. Address 0 is the data register, address 1 is the status register and address 2 is the configuration register. In the configuration register, bits 3:0 hold the word length minus one, so words of 1 to 16 bits are possible. The `master_en` input selects the role. As master, the block generates the serial clock at the system clock divided by `DIV`. As slave, it passes the incoming serial clock, select and data through a two-flop synchronizer and acts on the edges it detects. Three error conditions are recorded in sticky status bits: receive overrun, transmit underrun and a select break in the middle of a word. Software clears each of them by writing 1 to that bit.

Top module: `spi_dbuf_port`

## Requirements
- R1: After reset, the status register reads 0x00, the configuration register reads 15, `cs_n_o` is high and `sclk_o` is low.
- R2: The status bits are: bit7 mirrors receive-full, bit6 mirrors transmit-full, bit5 break, bit4 overrun, bit3 receive-full, bit2 transmit-full, bit1 transmitter running, bit0 underrun. Bits 15:8 read zero.
- R3: A data write while the transmitter is not running loads the transmit shifter directly. Running (bit1) becomes 1 and transmit-full (bit2) never becomes 1.
- R4: A data write while the transmitter is running and the holding register is empty sets transmit-full. The shifter takes that word when the current word ends, and in master mode it is sent back to back with `cs_n_o` held low.
- R5: A data write while transmit-full is set is ignored. The word is never sent.
- R6: In master mode, each word is sent MSB first in SPI mode 0 and is (config[3:0]+1) bits long. `sdo_o` is stable while `sclk_o` rises, and the `sclk_o` period is `DIV` system clocks. `cs_n_o` is low while a word is in progress and `sclk_o` is low while `cs_n_o` is high.
- R7: A read of address 0 returns the last received word in bits len:0, with every higher bit zero, and the read clears receive-full.
- R8: When a word completes while receive-full is already set and no read happens in the same cycle, the overrun bit sets and the new word replaces the old one.
- R9: In slave mode, data moves only on the synchronized external clock edges while `cs_n_i` is low. Input bits are sampled on the rising edge and `sdo_o` changes after the falling edge. A loaded word stays in place with no external clock.
- R10: In slave mode, the underrun bit sets when the external master begins a word and the transmitter holds no loaded word.
- R11: In slave mode, the break bit sets when `cs_n_i` changes while a word is partly received. The partial word is dropped and receive-full is not set.
- R12: The break, overrun and underrun bits stay set until software writes 1 to the bit in the status register. Writing 1 clears only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1 = master role, 0 = slave role |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 config |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| sclk_o | output | 1 | Serial clock driven in master mode |
| cs_n_o | output | 1 | Active-low select driven in master mode |
| sdo_o | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sclk_i | input | 1 | Serial clock from an external master |
| cs_n_i | input | 1 | Active-low select from an external master |
| sdi_i | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
The bench targets the write that lands while the transmitter is idle. A design that buffered that word first would show transmit-full for a cycle or would lose a start. It also sends two words back to back with a third write while the holding register is full. A wrong design would drop the second word, raise select between the words, or send the third word. It then lets a second word land on unread data, which must raise overrun and keep the newest word. In slave mode it runs a transfer with nothing loaded and raises select after three bits. A design that counted bits from the wrong edge, or kept the partial word, would report a bogus receive-full or miss the underrun and break bits. Both sticky flags are checked to stay set over time and to clear only on the write-1 path.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CFG  = 2'd2;

    localparam int unsigned ST_RXF_M = 7;
    localparam int unsigned ST_TXF_M = 6;
    localparam int unsigned ST_BRK   = 5;
    localparam int unsigned ST_OVR   = 4;
    localparam int unsigned ST_RXF   = 3;
    localparam int unsigned ST_TXF   = 2;
    localparam int unsigned ST_RUN   = 1;
    localparam int unsigned ST_URUN  = 0;
endpackage

// File: rtl/spi_dbuf_sync.sv
module spi_dbuf_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= RST;
                end else if (g == 0) begin
                    stg_q[g] <= d;
                end else begin
                    stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_dbuf_clkdiv.sv
module spi_dbuf_clkdiv #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          sclk_d, sclk_q;
    logic          tick;

    always_comb begin
        tick   = run && (cnt_q == CW'(HALF - 1));
        cnt_d  = cnt_q;
        sclk_d = sclk_q;
        if (!run) begin
            cnt_d  = '0;
            sclk_d = 1'b0;
        end else if (tick) begin
            cnt_d  = '0;
            sclk_d = !sclk_q;
        end else begin
            cnt_d  = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            sclk_q <= sclk_d;
        end
    end

    assign sclk = sclk_q;
    assign rise = tick && !sclk_q;
    assign fall = tick && sclk_q;
endmodule

// File: rtl/spi_dbuf_port.sv
module spi_dbuf_port
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned BW  = 16,
    parameter int unsigned DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_en,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    output logic          sclk_o,
    output logic          cs_n_o,
    output logic          sdo_o,
    input  logic          sclk_i,
    input  logic          cs_n_i,
    input  logic          sdi_i
);
    localparam int unsigned LW = $clog2(DW);

    typedef struct packed {
        logic [LW-1:0] len;
        logic [LW-1:0] bcnt;
        logic [DW-1:0] tx_sh;
        logic [DW-1:0] hold;
        logic [DW-1:0] rx_sh;
        logic [DW-1:0] rx_data;
        logic          hold_v;
        logic          busy;
        logic          fin;
        logic          active;
        logic          rx_full;
        logic          brk;
        logic          ovr;
        logic          urun;
        logic          sclk_p;
        logic          cs_p;
    } port_st_t;

    port_st_t s_d, s_q;

    logic       sclk_s, cs_s, sdi_s;
    logic       m_rise, m_fall, m_sclk;
    logic       word_done;
    logic [7:0] stat_w;
    logic [DW-1:0] mask_w;

    spi_dbuf_sync #(.W(3), .STAGES(2), .RST(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, cs_n_i, sdi_i}),
        .q     ({sclk_s, cs_s, sdi_s})
    );

    spi_dbuf_clkdiv #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (master_en && s_q.busy),
        .sclk  (m_sclk),
        .rise  (m_rise),
        .fall  (m_fall)
    );

    always_comb begin
        logic wr_data, wr_stat, wr_cfg, rd_data;
        logic s_rise, s_fall, cs_edge;

        wr_data = bus_wr && (bus_addr == A_DATA);
        wr_stat = bus_wr && (bus_addr == A_STAT);
        wr_cfg  = bus_wr && (bus_addr == A_CFG);
        rd_data = bus_rd && (bus_addr == A_DATA);
        mask_w  = {DW{1'b1}} >> (LW'(DW - 1) - s_q.len);
        word_done = 1'b0;

        s_d        = s_q;
        s_d.sclk_p = sclk_s;
        s_d.cs_p   = cs_s;
        // write-1-to-clear first so a set in this cycle wins
        if (wr_stat) begin
            s_d.brk  = s_q.brk  && !bus_wdata[ST_BRK];
            s_d.ovr  = s_q.ovr  && !bus_wdata[ST_OVR];
            s_d.urun = s_q.urun && !bus_wdata[ST_URUN];
        end
        if (wr_cfg) s_d.len = bus_wdata[LW-1:0];

        s_rise  = !cs_s && sclk_s && !s_q.sclk_p;
        s_fall  = !cs_s && !sclk_s && s_q.sclk_p && s_q.active;
        cs_edge = cs_s != s_q.cs_p;

        if (master_en) begin
            if (m_rise) begin
                s_d.rx_sh = {s_q.rx_sh[DW-2:0], sdi_i};
                if (s_q.bcnt == s_q.len) begin
                    s_d.fin   = 1'b1;
                    word_done = 1'b1;
                end else begin
                    s_d.bcnt = s_q.bcnt + LW'(1);
                end
            end
            if (m_fall) begin
                if (s_q.fin) begin
                    s_d.fin  = 1'b0;
                    s_d.bcnt = '0;
                    if (s_q.hold_v) begin
                        s_d.tx_sh  = s_q.hold;
                        s_d.hold_v = 1'b0;
                    end else begin
                        s_d.busy = 1'b0;
                    end
                end else begin
                    s_d.tx_sh = s_q.tx_sh << 1;
                end
            end
        end else if (cs_edge && s_q.active) begin
            // select moved mid-word: drop the partial word
            s_d.brk    = 1'b1;
            s_d.active = 1'b0;
            s_d.bcnt   = '0;
            if (s_q.hold_v) begin
                s_d.tx_sh  = s_q.hold;
                s_d.hold_v = 1'b0;
            end else begin
                s_d.tx_sh = '0;
                s_d.busy  = 1'b0;
            end
        end else if (cs_edge) begin
            s_d.bcnt = '0;
        end else if (s_rise) begin
            if (!s_q.active && !s_q.busy) s_d.urun = 1'b1;
            s_d.active = 1'b1;
            s_d.rx_sh  = {s_q.rx_sh[DW-2:0], sdi_s};
            if (s_q.bcnt == s_q.len) begin
                word_done  = 1'b1;
                s_d.active = 1'b0;
                s_d.bcnt   = '0;
                if (s_q.hold_v) begin
                    s_d.tx_sh  = s_q.hold;
                    s_d.hold_v = 1'b0;
                end else begin
                    s_d.tx_sh = '0;
                    s_d.busy  = 1'b0;
                end
            end else begin
                s_d.bcnt = s_q.bcnt + LW'(1);
            end
        end else if (s_fall) begin
            s_d.tx_sh = s_q.tx_sh << 1;
        end

        if (word_done) begin
            if (s_q.rx_full && !rd_data) s_d.ovr = 1'b1;
            s_d.rx_data = s_d.rx_sh & mask_w;
            s_d.rx_full = 1'b1;
        end else if (rd_data) begin
            s_d.rx_full = 1'b0;
        end

        // a full holding register blocks the write entirely
        if (wr_data && !s_q.hold_v) begin
            if (s_d.busy) begin
                s_d.hold   = bus_wdata[DW-1:0];
                s_d.hold_v = 1'b1;
            end else begin
                s_d.tx_sh = bus_wdata[DW-1:0];
                s_d.busy  = 1'b1;
                s_d.fin   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.len  <= LW'(DW - 1);
            s_q.cs_p <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_w = {s_q.rx_full, s_q.hold_v, s_q.brk, s_q.ovr,
                     s_q.rx_full, s_q.hold_v, s_q.busy, s_q.urun};

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = BW'(s_q.rx_data);
            A_STAT:  bus_rdata = {{(BW-8){1'b0}}, stat_w};
            A_CFG:   bus_rdata = {{(BW-LW){1'b0}}, s_q.len};
            default: bus_rdata = '0;
        endcase
    end

    assign sclk_o = m_sclk;
    assign cs_n_o = !(master_en && s_q.busy);
    assign sdo_o  = s_q.tx_sh[s_q.len];
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned BW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_en,
    input logic [1:0]    bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [BW-1:0] bus_wdata,
    input logic [7:0]    stat,
    input logic          word_done,
    input logic          sclk_o,
    input logic          cs_n_o
);
    logic wr_d, wr_s, rd_d;
    assign wr_d = bus_wr && (bus_addr == A_DATA);
    assign wr_s = bus_wr && (bus_addr == A_STAT);
    assign rd_d = bus_rd && (bus_addr == A_DATA);

    a_r3_idle_write_direct: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d && !stat[ST_RUN] && !stat[ST_TXF] |=> stat[ST_RUN] && !stat[ST_TXF]);

    a_r4_full_only_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_TXF] |-> stat[ST_RUN]);

    a_r6_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    a_r7_read_clears_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
        rd_d && !word_done |=> !stat[ST_RXF]);

    a_r8_overrun_needs_unread: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_OVR]) |-> $past(stat[ST_RXF]));

    a_r10_underrun_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_URUN]) |-> $past(!master_en));

    a_r11_break_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_BRK]) |-> $past(!master_en));

    a_r12_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_BRK] && !(wr_s && bus_wdata[ST_BRK]) |=> stat[ST_BRK]);

    a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_OVR] && !(wr_s && bus_wdata[ST_OVR]) |=> stat[ST_OVR]);

    a_r12_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_URUN] && !(wr_s && bus_wdata[ST_URUN]) |=> stat[ST_URUN]);
endmodule

bind spi_dbuf_port spi_dbuf_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .stat      (stat_w),
    .word_done (word_done),
    .sclk_o    (sclk_o),
    .cs_n_o    (cs_n_o)
);

// File: tb/spi_dbuf_port_bench.sv
module spi_dbuf_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1;
    logic [1:0]  b_addr = '0;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [15:0] b_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk_o, cs_n_o, sdo_o;
    logic        s_sclk = 1'b0, s_cs_n = 1'b1, s_sdi = 1'b0;
    logic        sdi_w;

    int n_tests = 0;
    int n_fail  = 0;
    int cur_len = 16;
    int words_seen = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];

    always #2 clk = !clk;

    // loopback in master role; bench drives the line in slave role
    assign sdi_w = master_en ? sdo_o : s_sdi;

    spi_dbuf_port u_spi_dbuf_port (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
        .bus_wdata(b_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .cs_n_o(cs_n_o), .sdo_o(sdo_o),
        .sclk_i(s_sclk), .cs_n_i(s_cs_n), .sdi_i(sdi_w)
    );

    function automatic logic [15:0] lmask(int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk); b_addr = a; b_wdata = d; b_wr = 1'b1;
        @(negedge clk); b_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk); b_addr = a; b_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); b_rd = 1'b0;
    endtask

    task automatic wait_stat(int bitn, logic val);
        logic [15:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(2'd1, v);
            if (v[bitn] == val) break;
        end
    endtask

    // driver: queue the expected master word, then write it
    task automatic m_send(logic [15:0] w);
        exp_q.push_back(w & lmask(cur_len));
        wr(2'd0, w);
    endtask

    task automatic set_len(int n);
        cur_len = n;
        wr(2'd2, 16'(n - 1));
    endtask

    // external master model for slave tests, 8 clocks per half period
    task automatic s_xfer(logic [15:0] mo, int nbits, bit full, output logic [15:0] mi);
        mi = '0;
        @(negedge clk); s_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            s_sdi = mo[nbits-1-i];
            repeat (8) @(negedge clk);
            mi = {mi[14:0], sdo_o};
            s_sclk = 1'b1;
            repeat (8) @(negedge clk);
            s_sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        if (full || nbits > 0) s_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // monitor: capture master output on each rising serial clock and compare
    logic        sclk_prev = 1'b0;
    logic [15:0] cap = '0;
    int          ccnt = 0;
    int          gap = 0;
    always @(negedge clk) begin
        if (rst_n && master_en) begin
            gap++;
            if (sclk_o && !sclk_prev) begin
                if (ccnt > 0) chk("R6 sclk period", 16'(gap), 16'd4);
                gap = 0;
                cap = {cap[14:0], sdo_o};
                ccnt++;
                if (ccnt == cur_len) begin
                    words_seen++;
                    if (exp_q.size() == 0) begin
                        chk("R5 unexpected word sent", cap & lmask(cur_len), 16'hDEAD);
                    end else begin
                        chk("R6 serial word", cap & lmask(cur_len), exp_q.pop_front());
                    end
                    ccnt = 0;
                    cap = '0;
                end
            end
        end
        sclk_prev = sclk_o;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] mi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); chk("R1 status after reset", v, 16'h0000);
        rd(2'd2, v); chk("R1 config after reset", v, 16'd15);
        chk("R1 cs_n_o idle", 16'(cs_n_o), 16'd1);
        chk("R1 sclk_o idle", 16'(sclk_o), 16'd0);

        // R3 R6 R7: single 8-bit word, upper write bits dropped
        set_len(8);
        m_send(16'h03A5);
        rd(2'd1, v); chk("R3 idle write goes to shifter", v, 16'h0002);
        wait_stat(1, 1'b0);
        rd(2'd1, v); chk("R2 status after receive", v, 16'h0088);
        rd(2'd0, v); chk("R7 received word", v, 16'h00A5);
        rd(2'd1, v); chk("R7 read clears rx full", v, 16'h0000);

        // R4 R5: back to back, third write ignored
        set_len(16);
        m_send(16'h1234);
        m_send(16'hBEEF);
        rd(2'd1, v); chk("R4 tx full while running", v, 16'h0046);
        wr(2'd0, 16'h5555);
        wait_stat(3, 1'b1);
        chk("R4 cs held low between words", 16'(cs_n_o), 16'd0);
        rd(2'd0, v); chk("R4 first word", v, 16'h1234);
        wait_stat(3, 1'b1);
        rd(2'd0, v); chk("R4 second word", v, 16'hBEEF);
        wait_stat(1, 1'b0);
        repeat (40) @(negedge clk);
        chk("R5 words sent", 16'(words_seen), 16'd3);
        chk("R6 cs high after last word", 16'(cs_n_o), 16'd1);
        rd(2'd1, v); chk("R5 status idle", v, 16'h0000);

        // R8 R12 overrun then clear
        set_len(4);
        m_send(16'h0009);
        wait_stat(1, 1'b0);
        m_send(16'h0006);
        wait_stat(1, 1'b0);
        rd(2'd1, v); chk("R8 overrun flagged", v, 16'h0098);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R12 overrun sticky", v, 16'h0098);
        wr(2'd1, 16'h0010);
        rd(2'd1, v); chk("R12 write-1 clears overrun only", v, 16'h0088);
        rd(2'd0, v); chk("R8 newest word kept", v, 16'h0006);

        // R6 one-bit word
        set_len(1);
        m_send(16'hFFFF);
        wait_stat(1, 1'b0);
        rd(2'd0, v); chk("R6 one-bit word", v, 16'h0001);

        // slave role
        @(negedge clk); master_en = 1'b0;
        set_len(8);
        wr(2'd0, 16'h00C3);
        rd(2'd1, v); chk("R3 slave idle write", v, 16'h0002);
        repeat (50) @(negedge clk);
        rd(2'd1, v); chk("R9 no shifting without clock", v, 16'h0002);
        s_xfer(16'h005A, 8, 1'b1, mi);
        chk("R9 slave output word", mi, 16'h00C3);
        rd(2'd1, v); chk("R9 slave status after word", v, 16'h0088);
        rd(2'd0, v); chk("R9 slave received word", v, 16'h005A);

        // R10 underrun
        s_xfer(16'h003C, 8, 1'b1, mi);
        rd(2'd1, v); chk("R10 underrun flagged", v, 16'h0089);
        rd(2'd0, v); chk("R10 data still received", v, 16'h003C);
        wr(2'd1, 16'h0001);
        rd(2'd1, v); chk("R12 underrun cleared", v, 16'h0000);

        // R11 break after three bits
        wr(2'd0, 16'h0081);
        s_xfer(16'h00FF, 3, 1'b0, mi);
        rd(2'd1, v); chk("R11 break, no rx full", v, 16'h0020);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R12 break sticky", v, 16'h0020);
        wr(2'd1, 16'h0020);
        rd(2'd1, v); chk("R12 break cleared", v, 16'h0000);

        summary();
    end
endmodule